// File: doc/BRIEF.md
# Auto-Incrementing Register Access Front End

This block sits behind the byte engine of a serial-bus target. It receives decoded transfer events and turns them into register accesses. A start-of-write pulse arms the block. The next byte it accepts is taken as the register pointer, and every later written byte is stored at the pointer. Each accepted read request returns the register at the pointer. Both kinds of access then advance the pointer by one, wrapping from 0xFF to 0x00.

A small bank of control registers lives inside the block, and each one shapes its writes in its own way. A fixed revision code returns 0x22 and ignores writes. Two supply-level registers keep the low five bits of the byte and clamp them to a ceiling. An oscillator register keeps three bits and reads back with a clock-good flag. A power-down register can return every register to its reset value. A contiguous address window is passed through to an external register port. Any other address reads as zero and ignores writes.

Written bytes arrive on a valid/ready stream whose ready is always high. Read requests form a second valid/ready stream. Each accepted request produces one response beat on a third valid/ready stream that the consumer may stall.

Top module: `serial_reg_frontend`

## Requirements
- R1: After `wr_start`, the first accepted byte loads the pointer and causes no register write. There is no start-of-read event, so a read after the address byte reads from that address.
- R2: Each later accepted byte writes the register at the pointer, and the pointer then increments. A write into the external window [0x16, 0x3A] raises `ext_wr_en` in the accept cycle, with `ext_addr` set to the pointer and `ext_wdata` set to the byte.
- R3: An accepted read request presents the register at the pointer on `rsp_data`, with `rsp_valid` high, from the next cycle. The pointer then increments. For an external address, `ext_rdata` is sampled in the accept cycle.
- R4: Address 0x01 always reads 0x22, and writes to it are ignored.
- R5: Addresses 0x04 and 0x05 store min(byte & 0x1F, 0x12). Their reset values are 0x02 and 0x0C.
- R6: Address 0x15 stores byte & 0x07 and reads back as that value OR 0x80. Its reset value is 0x01, so it reads 0x81 after reset.
- R7: A write to 0x14 with bit 0 set returns the internal registers to their reset values and pulses `ext_clr` in that cycle. A write with bit 0 clear has no effect. Address 0x14 reads 0x00.
- R8: Addresses outside the window that have no register read 0x00. Writes to them change nothing and raise no `ext_wr_en`.
- R9: The pointer wraps from 0xFF to 0x00.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `rq_ready` is low. `rq_ready` is also low in any cycle with `in_valid` or `wr_start` high.
- R11: After reset the pointer is 0x00 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start-of-write-transfer pulse |
| in_valid | input | 1 | Written byte valid |
| in_ready | output | 1 | Written byte ready (always 1) |
| in_data | input | 8 | Written byte |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| ext_addr | output | 8 | External port address (the pointer) |
| ext_wr_en | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |
| ext_rd_en | output | 1 | External read strobe |
| ext_rdata | input | 8 | External read data, same cycle |
| ext_clr | output | 1 | Power-down reset pulse to external registers |

## Verification
The assertions assume that `wr_start` and `in_valid` are never high together. They also assume that the external port returns its data in the same cycle as the read strobe. The stimulus keeps to this by raising at most one of `wr_start`, `in_valid` and `rq_valid` per cycle, and by serving `ext_rdata` combinationally from a model memory. The consumer stalls `rsp_ready` both in directed stretches and at random, so the hold rules are exercised while a response is pending.

// File: rtl/reg_fe_pkg.sv
package reg_fe_pkg;
  localparam logic [7:0] A_REV = 8'h01;
  localparam logic [7:0] A_VC0 = 8'h04;
  localparam logic [7:0] A_VC1 = 8'h05;
  localparam logic [7:0] A_OFF = 8'h14;
  localparam logic [7:0] A_OSC = 8'h15;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_REV, CLS_VC, CLS_OFF, CLS_OSC, CLS_EXT
  } acc_cls_e;

  function automatic acc_cls_e classify(input logic [7:0] a,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    if (a >= lo && a <= hi) return CLS_EXT;
    case (a)
      A_REV:        return CLS_REV;
      A_VC0, A_VC1: return CLS_VC;
      A_OFF:        return CLS_OFF;
      A_OSC:        return CLS_OSC;
      default:      return CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/regfe_ptr.sv
module regfe_ptr #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          byte_fire,
  input  logic [DW-1:0] byte_data,
  input  logic          rd_fire,
  output logic [AW-1:0] ptr,
  output logic          wr_hit
);
  logic armed;

  assign wr_hit = byte_fire && !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ptr   <= '0;
    end else if (wr_start) begin
      armed <= 1'b1;
    end else if (byte_fire && armed) begin
      armed <= 1'b0;
      ptr   <= AW'(byte_data);
    end else if (wr_hit || rd_fire) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_addr_byte_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_start) && byte_fire |-> !wr_hit);
  assert_load_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_start) && byte_fire |=> ptr == AW'($past(byte_data)));
  assert_rd_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ptr == AW'($past(ptr) + 1'b1));
endmodule

// File: rtl/regfe_bank.sv
module regfe_bank
  import reg_fe_pkg::*;
#(
  parameter int         DW     = 8,
  parameter logic [7:0] REV_ID = 8'h22,
  parameter logic [4:0] VC_MAX = 5'h12,
  parameter logic [7:0] EXT_LO = 8'h16,
  parameter logic [7:0] EXT_HI = 8'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          soft_clr
);
  localparam int NVC = 2;
  localparam logic [4:0] VC_RST [NVC] = '{5'h02, 5'h0C};
  localparam logic [7:0] VC_ADR [NVC] = '{A_VC0, A_VC1};
  localparam logic [2:0] OSC_RST = 3'h1;

  acc_cls_e cls;
  logic [4:0] vc_q [NVC];
  logic [2:0] osc_q;
  logic [4:0] vc_new;

  assign cls      = classify(addr, EXT_LO, EXT_HI);
  assign soft_clr = wr_en && cls == CLS_OFF && wdata[0];
  assign vc_new   = (wdata[4:0] > VC_MAX) ? VC_MAX : wdata[4:0];

  for (genvar i = 0; i < NVC; i++) begin : g_vc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             vc_q[i] <= VC_RST[i];
      else if (soft_clr)                      vc_q[i] <= VC_RST[i];
      else if (wr_en && addr == VC_ADR[i])    vc_q[i] <= vc_new;
    end
    assert_vc_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vc_q[i] <= VC_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          osc_q <= OSC_RST;
    else if (soft_clr)                   osc_q <= OSC_RST;
    else if (wr_en && cls == CLS_OSC)    osc_q <= wdata[2:0];
  end

  always_comb begin
    rd_data = '0;
    case (cls)
      CLS_REV: rd_data = DW'(REV_ID);
      CLS_VC:  rd_data = DW'(vc_q[addr == A_VC1 ? 1 : 0]);
      CLS_OSC: rd_data = DW'({5'b10000, osc_q});
      default: rd_data = '0;
    endcase
  end

  assert_clr_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> osc_q == OSC_RST && vc_q[0] == VC_RST[0] && vc_q[1] == VC_RST[1]);
endmodule

// File: rtl/serial_reg_frontend.sv
module serial_reg_frontend
  import reg_fe_pkg::*;
#(
  parameter int         DW     = 8,
  parameter logic [7:0] REV_ID = 8'h22,
  parameter logic [4:0] VC_MAX = 5'h12,
  parameter logic [7:0] EXT_LO = 8'h16,
  parameter logic [7:0] EXT_HI = 8'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          rq_valid,
  output logic          rq_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [7:0]    ext_addr,
  output logic          ext_wr_en,
  output logic [DW-1:0] ext_wdata,
  output logic          ext_rd_en,
  input  logic [DW-1:0] ext_rdata,
  output logic          ext_clr
);
  localparam int AW = 8;

  logic [AW-1:0] ptr;
  logic          wr_hit, rd_fire, is_ext;
  logic [DW-1:0] bank_rd, rd_mux;

  assign in_ready = 1'b1;
  assign rq_ready = (!rsp_valid || rsp_ready) && !in_valid && !wr_start;
  assign rd_fire  = rq_valid && rq_ready;
  assign is_ext   = classify(ptr, EXT_LO, EXT_HI) == CLS_EXT;

  regfe_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start),
    .byte_fire(in_valid), .byte_data(in_data), .rd_fire(rd_fire),
    .ptr(ptr), .wr_hit(wr_hit));

  regfe_bank #(.DW(DW), .REV_ID(REV_ID), .VC_MAX(VC_MAX),
               .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit && !is_ext), .addr(ptr),
    .wdata(in_data), .rd_data(bank_rd), .soft_clr(ext_clr));

  assign ext_addr  = ptr;
  assign ext_wdata = in_data;
  assign ext_wr_en = wr_hit && is_ext;
  assign ext_rd_en = rd_fire && is_ext;
  assign rd_mux    = is_ext ? ext_rdata : bank_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_inputs_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_start && in_valid));
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rq_ready);
  assert_rev_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && ptr == A_REV |=> rsp_data == DW'(REV_ID));
  assert_ext_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |-> ext_addr >= EXT_LO && ext_addr <= EXT_HI);
  assert_off_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && ptr == A_OFF |=> rsp_data == '0);
endmodule

// File: tb/serial_reg_frontend_test.sv
module serial_reg_frontend_test;
  logic clk = 0, rst_n = 0;
  logic wr_start = 0, in_valid = 0, rq_valid = 0, rsp_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, rq_ready, rsp_valid, ext_wr_en, ext_rd_en, ext_clr;
  logic [7:0] rsp_data, ext_addr, ext_wdata, ext_rdata;

  int checks = 0, errors = 0, cyc_n = 0;
  bit done = 0;

  // model state
  int m_ptr = 0; bit m_first = 0;
  int m_vc0 = 2, m_vc1 = 12, m_osc = 1;
  bit m_rv = 0; int m_rd = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;
  assign ext_rdata = mem[ext_addr];

  serial_reg_frontend uut (.*);

  function automatic bit in_win(int a); return a >= 'h16 && a <= 'h3A; endfunction
  function automatic int mread(int a);
    if (in_win(a)) return mem[a];
    case (a)
      1: return 'h22;  4: return m_vc0;  5: return m_vc1;
      'h15: return m_osc | 'h80;
      default: return 0;
    endcase
  endfunction
  function automatic int clampv(int d);
    return ((d & 'h1F) > 'h12) ? 'h12 : (d & 'h1F);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input bit ws, input bit iv, input int d, input bit rq, input bit rr);
    bit exp_rqr, wr, acc;
    wr_start = ws; in_valid = iv; in_data = d[7:0]; rq_valid = rq; rsp_ready = rr;
    #1;
    exp_rqr = (!m_rv || rr) && !iv && !ws;
    wr = iv && !m_first && !ws;
    chk("R10 rq_ready", rq_ready, exp_rqr);
    chk("R2/R8 ext_wr_en", ext_wr_en, wr && in_win(m_ptr));
    if (wr && in_win(m_ptr)) begin
      chk("R2 ext_addr", ext_addr, m_ptr);
      chk("R2 ext_wdata", ext_wdata, d & 'hFF);
    end
    chk("R7 ext_clr", ext_clr, wr && m_ptr == 'h14 && d[0]);
    chk("R3 rsp_valid", rsp_valid, m_rv);
    if (m_rv) chk("R3 rsp_data", rsp_data, m_rd);
    chk("R1 in_ready", in_ready, 1);
    acc = rq && exp_rqr;
    @(posedge clk);
    if (m_rv && rr) m_rv = 0;
    if (ws) m_first = 1;
    else if (iv && m_first) begin m_ptr = d & 'hFF; m_first = 0; end
    else if (iv) begin
      if (in_win(m_ptr)) mem[m_ptr] = d[7:0];
      else case (m_ptr)
        4: m_vc0 = clampv(d);
        5: m_vc1 = clampv(d);
        'h15: m_osc = d & 7;
        'h14: if (d[0]) begin m_vc0 = 2; m_vc1 = 12; m_osc = 1; end
        default: ;
      endcase
      m_ptr = (m_ptr + 1) & 'hFF;
    end else if (acc) begin
      m_rd = mread(m_ptr); m_rv = 1; m_ptr = (m_ptr + 1) & 'hFF;
    end
    @(negedge clk);
  endtask

  task automatic set_ptr(input int a); cyc(1,0,0,0,1); cyc(0,1,a,0,1); endtask
  task automatic wbyte(input int d); cyc(0,1,d,0,1); endtask
  task automatic rd1(); cyc(0,0,0,1,1); endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 rq_ready", rq_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R11/R3/R5/R6: walk from reset pointer 0x00 through 0x17
    for (int i = 0; i < 24; i++) rd1();
    cyc(0,0,0,0,1);
    // R4: revision write ignored
    set_ptr(1); wbyte('h55); set_ptr(1); rd1(); rd1();
    // R5: clamp
    set_ptr(4); wbyte('h1F); wbyte('h11); set_ptr(4); rd1(); rd1();
    set_ptr(5); wbyte('hFF); set_ptr(4); rd1(); rd1();
    // R6: osc
    set_ptr('h15); wbyte('hFF); set_ptr('h15); rd1();
    // R7: bit0 clear no effect, then bit0 set resets
    set_ptr('h14); wbyte('hFE); set_ptr(4); rd1(); rd1();
    set_ptr('h14); wbyte('h01); set_ptr(4); rd1(); rd1();
    set_ptr('h14); rd1(); rd1();
    // R2: external burst and readback
    set_ptr('h20); for (int i = 0; i < 6; i++) wbyte('hA0 + i);
    set_ptr('h20); for (int i = 0; i < 6; i++) rd1();
    // R8: unimplemented addresses
    set_ptr('h40); wbyte('h99); set_ptr('h40); rd1();
    set_ptr('h3B); wbyte('h77); set_ptr('h3A); rd1(); rd1();
    // R9: wrap
    set_ptr('hFF); rd1(); rd1(); rd1();
    set_ptr('hFF); wbyte('h12); wbyte('h33); set_ptr(1); rd1();
    // R10: back-pressure
    set_ptr('h20); cyc(0,0,0,1,0); cyc(0,0,0,1,0); cyc(0,0,0,1,0);
    cyc(0,0,0,1,1); cyc(0,0,0,0,0); cyc(0,0,0,0,1);
    // R1: repeated start then reads from loaded address
    set_ptr('h30); cyc(1,0,0,0,1); cyc(0,0,0,1,1); cyc(0,0,0,1,1);
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 9);
      bit rr = ($urandom_range(0, 3) != 0);
      if (r == 0) cyc(1,0,0,0,rr);
      else if (r < 4) cyc(0,1,$urandom_range(0,255),0,rr);
      else if (r < 8) cyc(0,0,0,1,rr);
      else cyc(0,0,0,0,rr);
    end
    cyc(0,0,0,0,1); cyc(0,0,0,0,1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule